// File: doc/BRIEF.md
# Reloading Periodic Timer Channel

This block is one down-counting timer channel behind a 32-bit register port. Software programs a fixed period value into the count register. The counter then steps down to zero. On the step after it reaches zero, the channel expires. At each expiry it raises a sticky status flag. With the reload option set, it also refills itself from the fixed value and keeps running as a periodic tick source. Without it, the channel fires once and then stops.

The control register has four addresses. One replaces the value, one sets bits, one clears bits and one toggles bits. Software can therefore change a single field without reading the register first. Software acknowledges an expiry by writing a one to the status bit at the clear address. The interrupt request is a level that stays high while the status flag and the enable bit are both set.

The counter can step on every clock. It can instead step only on cycles where the slow tick-enable input is high, which suits a tick of about 32 kHz. Clock generation and bus bridging belong to the surrounding design.

Top module: `reload_timer_chan`

## Requirements
- R1: After reset, control reads 0, the count register reads 0 and irq is low. No expiry occurs until the count register has been written.
- R2: Control has four write addresses, each applied with `wdata` (old = current control value):
  - 0x00 replaces control with `wdata`.
  - 0x04 ORs `wdata` into control.
  - 0x08 computes control AND NOT `wdata`.
  - 0x0C XORs `wdata` into control.

  All four addresses read back control. Only bits 3, 5, 6, 7 and 14 are stored; every other bit reads 0.
- R3: With control bit 3 (slow source) set, the counter changes only in cycles where `tick_en` is high. With bit 3 clear, it steps on every clock.
- R4: A write to 0x10 stores `wdata[15:0]` as the fixed count. A read of 0x10 returns the fixed count in bits 15:0 and the live counter in bits 31:16.
- R5: With control bit 6 (reload) set, a step taken while the counter is 0 is an expiry, and the counter reloads the fixed count. Expiries therefore repeat every fixed+1 steps.
- R6: With bit 6 clear, the counter stays at 0 after an expiry. No further expiry occurs until the count register is written again.
- R7: Control bit 5 (status) becomes 1 in the cycle after an expiry. It stays 1 until a one is written to bit 5 at address 0x08.
- R8: `irq` is high exactly when status (bit 5) and interrupt enable (bit 14) are both 1.
- R9: With control bit 7 (update) set, a count write also loads the counter on the same clock edge. With bit 7 clear, the counter keeps its value and the new fixed count is used at the next reload.
- R10: If an expiry and a clear of the status bit happen on the same clock edge, status is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Slow tick enable, one cycle per tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte offset in the 0x20-byte window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
A register write takes effect on the clock edge where `wr_en` is sampled. Its result is visible on `rdata` and `irq` half a cycle later, because reads are combinational from the registers.

An expiry on a step edge shows up on the status bit and `irq` at that same edge, with the reloaded count beside it. The bench drives each input on a falling edge and samples just before the next falling edge. It counts exactly the step edges it produced, so every expected count and flag refers to a known edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 5;

  // register slots, decoded from addr[4:2]
  localparam logic [2:0] SLOT_CTRL = 3'd0;
  localparam logic [2:0] SLOT_SET  = 3'd1;
  localparam logic [2:0] SLOT_CLR  = 3'd2;
  localparam logic [2:0] SLOT_TOG  = 3'd3;
  localparam logic [2:0] SLOT_CNT  = 3'd4;

  // control bit positions
  localparam int B_SLOW   = 3;
  localparam int B_STAT   = 5;
  localparam int B_RELOAD = 6;
  localparam int B_UPDATE = 7;
  localparam int B_IEN    = 14;

  localparam logic [REG_W-1:0] CTRL_KEEP =
    (REG_W'(1) << B_SLOW) | (REG_W'(1) << B_STAT) | (REG_W'(1) << B_RELOAD) |
    (REG_W'(1) << B_UPDATE) | (REG_W'(1) << B_IEN);

  typedef enum logic [1:0] {OP_WRITE, OP_SET, OP_CLEAR, OP_FLIP} alias_op_e;

  function automatic logic [REG_W-1:0] alias_apply(
    input logic [REG_W-1:0] cur, input logic [REG_W-1:0] d, input alias_op_e op);
    logic [REG_W-1:0] r;
    case (op)
      OP_SET:   r = cur | d;
      OP_CLEAR: r = cur & ~d;
      OP_FLIP:  r = cur ^ d;
      default:  r = d;
    endcase
    return r & CTRL_KEEP;
  endfunction
endpackage

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
  import rtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              expire,
  output logic [REG_W-1:0]  ctrl,
  output logic [CNT_W-1:0]  fixed_cnt,
  output logic              cnt_wr,
  output logic              load_now
);
  logic [2:0]       slot;
  logic             ctrl_wr;
  logic             stat_ack;
  alias_op_e        op;
  logic [REG_W-1:0] ctrl_next;

  assign slot     = addr[4:2];
  assign ctrl_wr  = wr_en && (slot <= SLOT_TOG);
  assign cnt_wr   = wr_en && (slot == SLOT_CNT);
  assign load_now = cnt_wr && ctrl[B_UPDATE];
  assign stat_ack = ctrl_wr && (slot == SLOT_CLR) && wdata[B_STAT];
  assign op       = alias_op_e'(slot[1:0]);

  always_comb begin
    ctrl_next = ctrl_wr ? alias_apply(ctrl, wdata, op) : ctrl;
    if (expire) ctrl_next[B_STAT] = 1'b1;  // expiry wins over any clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      fixed_cnt <= '0;
    end else begin
      ctrl <= ctrl_next;
      if (cnt_wr) fixed_cnt <= wdata[CNT_W-1:0];
    end
  end

  AST_EXPIRY_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> ctrl[B_STAT]);  // R7
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[B_STAT] && !ctrl_wr |=> ctrl[B_STAT]);  // R7
  AST_ACK_RACE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_ack && expire |=> ctrl[B_STAT]);  // R10
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             reload_mode,
  input  logic             cnt_wr,
  input  logic             load_now,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] fixed_cnt,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic armed;

  function automatic logic [CNT_W-1:0] cnt_next(
    input logic [CNT_W-1:0] c, input logic st, input logic ex,
    input logic rl, input logic [CNT_W-1:0] fx);
    if (ex)              return rl ? fx : '0;
    else if (st && c != '0) return c - CNT_W'(1);
    else                 return c;
  endfunction

  assign expire = step && armed && (cnt == '0) && !load_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else begin
      if (load_now) cnt <= load_val;
      else          cnt <= cnt_next(cnt, step, expire, reload_mode, fixed_cnt);
      if (cnt_wr)                       armed <= 1'b1;
      else if (expire && !reload_mode)  armed <= 1'b0;
    end
  end

  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load_now && cnt != '0 |=> cnt == $past(cnt) - CNT_W'(1));  // R5
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    expire && reload_mode |=> cnt == $past(fixed_cnt));  // R5
  AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !reload_mode && !cnt_wr |=> cnt == '0 && !expire);  // R6
  AST_LOAD_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> cnt == $past(load_val));  // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !load_now |=> $stable(cnt));  // R3
endmodule

// File: rtl/reload_timer_chan.sv
module reload_timer_chan
  import rtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              irq
);
  localparam int RD_HI = 2 * CNT_W;

  logic [REG_W-1:0] ctrl;
  logic [CNT_W-1:0] fixed_cnt;
  logic [CNT_W-1:0] cnt;
  logic             cnt_wr, load_now, expire, step;

  tmr_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .expire(expire), .ctrl(ctrl), .fixed_cnt(fixed_cnt),
    .cnt_wr(cnt_wr), .load_now(load_now)
  );

  assign step = ctrl[B_SLOW] ? tick_en : 1'b1;

  tmr_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .reload_mode(ctrl[B_RELOAD]),
    .cnt_wr(cnt_wr), .load_now(load_now), .load_val(wdata[CNT_W-1:0]),
    .fixed_cnt(fixed_cnt), .cnt(cnt), .expire(expire)
  );

  assign irq = ctrl[B_STAT] && ctrl[B_IEN];

  always_comb begin
    rdata = '0;
    if (addr[4:2] <= SLOT_TOG) rdata = ctrl;
    else if (addr[4:2] == SLOT_CNT) begin
      rdata[CNT_W-1:0]     = fixed_cnt;
      rdata[RD_HI-1:CNT_W] = cnt;
    end
  end

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ctrl[B_IEN] && ctrl[B_STAT]);  // R8
  AST_NO_EARLY_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> cnt == '0);  // R5
endmodule

// File: tb/reload_timer_chan_bench.sv
module reload_timer_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  localparam logic [31:0] SLOW = 32'h8, STAT = 32'h20, RLD = 32'h40,
                          UPD = 32'h80, IEN = 32'h4000, KEEP = 32'h40E8;

  reload_timer_chan u_reload_timer_chan (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] model_ctrl(logic [31:0] o, logic [4:0] a, logic [31:0] d);
    logic [31:0] r;
    if (a == 5'h04)      r = d | o;
    else if (a == 5'h08) r = ~d & o;
    else if (a == 5'h0C) r = (o & ~d) | (~o & d);
    else                 r = d;
    return KEEP & r;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d, bit tk = 0);
    addr = a; wdata = d; wr_en = 1'b1; tick_en = tk;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1; @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  initial begin
    logic [31:0] v, mc;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(5'h00, v); chk("R1 ctrl after reset", v, 32'h0);
    rd(5'h10, v); chk("R1 count after reset", v, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);

    // R2: random alias traffic on control
    mc = '0;
    for (int i = 0; i < 40; i++) begin
      logic [4:0] a;
      logic [31:0] d;
      a = 5'($urandom_range(0, 3) * 4);
      d = $urandom();
      wr(a, d);
      mc = model_ctrl(mc, a, d);
      rd(5'($urandom_range(0, 3) * 4), v);
      chk("R2 alias result", v, mc);
      chk("R8 irq level", {31'b0, irq}, {31'b0, mc[5] & mc[14]});
    end

    // R4/R9/R5: slow source, update, reload, period 5
    wr(5'h00, SLOW | UPD | RLD);
    wr(5'h10, 32'hABCD0004);
    rd(5'h10, v); chk("R4 R9 count readback", v, 32'h00040004);
    repeat (4) @(negedge clk);
    rd(5'h10, v); chk("R3 hold without tick", v, 32'h00040004);
    tick(4);
    rd(5'h00, v); chk("R5 no expiry before period", v & STAT, 32'h0);
    rd(5'h10, v); chk("R5 counter at zero", v, 32'h00000004);
    tick(1);
    rd(5'h00, v); chk("R7 status on expiry", v & STAT, STAT);
    rd(5'h10, v); chk("R5 reloaded", v, 32'h00040004);
    chk("R8 irq masked", {31'b0, irq}, 32'h0);
    wr(5'h04, IEN);
    chk("R8 irq high", {31'b0, irq}, 32'h1);
    wr(5'h0C, 32'h0);  // toggle with zero leaves status
    rd(5'h00, v); chk("R7 status sticky", v & STAT, STAT);
    wr(5'h08, STAT);
    rd(5'h00, v); chk("R7 status acked", v & STAT, 32'h0);
    chk("R8 irq drops", {31'b0, irq}, 32'h0);

    // R9: update clear, new value waits for the reload
    wr(5'h08, UPD);
    wr(5'h10, 32'h00000009);
    rd(5'h10, v); chk("R9 deferred load", v, 32'h00040009);
    tick(5);
    rd(5'h10, v); chk("R9 reload takes new", v, 32'h00090009);

    // R6: one-shot
    wr(5'h00, SLOW | UPD);
    wr(5'h10, 32'h1);
    tick(2);
    rd(5'h00, v); chk("R6 one-shot expiry", v & STAT, STAT);
    wr(5'h08, STAT);
    tick(3);
    rd(5'h00, v); chk("R6 no second expiry", v & STAT, 32'h0);
    rd(5'h10, v); chk("R6 parked at zero", v, 32'h00000001);

    // R10: expiry on the same edge as the acknowledge
    wr(5'h00, SLOW | UPD | RLD | IEN);
    wr(5'h10, 32'h0);
    wr(5'h08, STAT, 1);
    rd(5'h00, v); chk("R10 expiry beats clear", v & STAT, STAT);
    chk("R10 irq kept", {31'b0, irq}, 32'h1);

    // R3: every-clock source, period 3
    wr(5'h00, UPD | RLD);
    wr(5'h10, 32'h2);
    rd(5'h10, v); chk("R3 loaded", v, 32'h00020002);
    wr(5'h08, STAT);
    rd(5'h10, v); chk("R3 steps per clock", v, 32'h00010002);
    @(negedge clk);
    rd(5'h00, v); chk("R3 no early expiry", v & STAT, 32'h0);
    @(negedge clk);
    rd(5'h00, v); chk("R3 expiry on clock", v & STAT, STAT);

    // R5: random periods on the slow source
    wr(5'h00, SLOW | UPD | RLD);
    for (int k = 0; k < 6; k++) begin
      int n;
      n = $urandom_range(1, 9);
      wr(5'h10, 32'(n - 1));
      wr(5'h08, STAT);
      tick(n - 1);
      rd(5'h00, v); chk("R5 random no early", v & STAT, 32'h0);
      tick(1);
      rd(5'h00, v); chk("R5 random expiry", v & STAT, STAT);
      rd(5'h10, v); chk("R5 random reload", v, {16'(n - 1), 16'(n - 1)});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule